// File: doc/BRIEF.md
# Four-Way Victim Selector with Selectable Replacement Policy

This block picks the way to replace in one 4-way cache set and keeps the replacement history for that set up to date. A two-bit mode input chooses among four policies: a 3-bit binary-tree approximation of least-recently-used, a round-robin fill order, a pseudo-random draw from a shift register, and least-frequently-used with saturating per-way counters that are periodically halved. All four histories are tracked in parallel on every cycle, so the mode can change at any time and the new policy applies at once.

The cache controller pulses the access strobe with the way that hit, pulses the fill strobe with the way that was just loaded, and supplies the valid bit of each way. The victim way is a combinational function of the stored history and the valid bits, so it is ready in any cycle. A victim-request strobe marks each consumption of a victim and steps the random source. Tag storage, data arrays and miss handling belong to the surrounding cache. To cover many sets, replicate this state once per set.

Top module: `way_victim_sel`

## Requirements
- R1: After reset, with all ways valid, the victim is way 3 in tree mode (code 0), way 0 in round-robin mode (code 1), way 1 in random mode (code 2, seed 8'hA5) and way 0 in frequency mode (code 3).
- R2: When any valid bit is 0, the victim is the lowest-numbered invalid way, whatever mode is selected.
- R3: The tree keeps a root bit (0 means ways 0/1 were used last, 1 means ways 2/3) and one bit per pair (0 means the lower way of that pair, 1 the upper). A hit or fill on way w sets the root to w[1] and the bit of that pair to w[0]; the other pair's bit keeps its value. When a hit and a fill arrive together, the fill's update is the one applied.
- R4: In tree mode the victim lies in the pair opposite the root, and within that pair is the way opposite that pair's bit.
- R5: In round-robin mode the victim is a pointer that steps by one on each fill, wrapping from 3 to 0; hits do not move it.
- R6: In random mode the victim is bits [1:0] of an 8-bit register that starts at 8'hA5 and, on each victim request, shifts left taking in bit7^bit5^bit4^bit3 at bit 0.
- R7: In frequency mode a hit adds one to that way's 4-bit counter, saturating at 15, and a fill sets the filled way's counter to 1.
- R8: In frequency mode the victim is the way with the smallest counter; on a tie the lowest way index wins.
- R9: Hits are counted; on every AGE_PERIOD-th hit since reset, all four counters are halved (after that hit's own increment).

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| policy_i | input | 2 | Replacement mode: 0 tree, 1 round-robin, 2 random, 3 frequency |
| acc_vld_i | input | 1 | Hit strobe |
| acc_way_i | input | 2 | Way that hit |
| fill_vld_i | input | 1 | Fill strobe |
| fill_way_i | input | 2 | Way that was loaded |
| vic_req_i | input | 1 | Victim consumed; steps the random source |
| way_valid_i | input | 4 | Valid bit of each way |
| victim_o | output | 2 | Way to replace |

## Verification
Every history register updates on the rising edge where its strobe is high, and the victim is derived combinationally from those registers, so the effect of a strobe is due on the victim output one edge after it is applied, while a change of mode or valid bits is due in the same cycle. The bench drives strobes on the falling edge for exactly one cycle and compares the victim on the next falling edge, after the single update edge and before any further stimulus. Sequences of hits and fills are chosen so that a wrong tree bit, a missing saturation, a missing halving or a pointer moved by a hit each leaves a different victim than the correct design.

// File: rtl/way_victim_pkg.sv
package way_victim_pkg;

    localparam int NWAYS  = 4;
    localparam int WAY_W  = 2;
    localparam int LFSR_W = 8;

    typedef enum logic [1:0] {
        POL_TREE  = 2'd0,
        POL_ROUND = 2'd1,
        POL_RAND  = 2'd2,
        POL_FREQ  = 2'd3
    } repl_pol_e;

    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        logic root;   // 0: pair {0,1} used last, 1: pair {2,3}
        logic lo;     // within {0,1}: 0 way0 last, 1 way1 last
        logic hi;     // within {2,3}: 0 way2 last, 1 way3 last
    } tree_t;

    function automatic tree_t tree_touch(tree_t t, way_t w);
        tree_t n;
        n      = t;
        n.root = w[1];
        if (w[1]) n.hi = w[0];
        else      n.lo = w[0];
        return n;
    endfunction

    function automatic way_t tree_pick(tree_t t);
        if (t.root) return {1'b0, ~t.lo};
        else        return {1'b1, ~t.hi};
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/tree_plru.sv
module tree_plru
    import way_victim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_vld,
    input  way_t acc_way,
    input  logic fill_vld,
    input  way_t fill_way,
    output way_t victim
);
    tree_t state_q;

    always_ff @(posedge clk) begin
        if (rst)           state_q <= '0;
        else if (fill_vld) state_q <= tree_touch(state_q, fill_way);
        else if (acc_vld)  state_q <= tree_touch(state_q, acc_way);
    end

    assign victim = tree_pick(state_q);

    // the touched way is never the next victim
    p_touched_not_victim_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !fill_vld) |=> (victim != $past(acc_way)));

    p_root_follows_r3: assert property (@(posedge clk) disable iff (rst)
        fill_vld |=> (state_q.root == $past(fill_way[1])));
endmodule

// File: rtl/round_ptr.sv
module round_ptr
    import way_victim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fill_vld,
    output way_t victim
);
    way_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst)           ptr_q <= '0;
        else if (fill_vld) ptr_q <= ptr_q + way_t'(1);
    end

    assign victim = ptr_q;

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        fill_vld |=> (ptr_q == way_t'($past(ptr_q) + way_t'(1))));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !fill_vld |=> $stable(ptr_q));
endmodule

// File: rtl/lfsr_pick.sv
module lfsr_pick
    import way_victim_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 8'hA5
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output way_t victim
);
    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst)       lfsr_q <= SEED;
        else if (step) lfsr_q <= lfsr_step(lfsr_q);
    end

    assign victim = lfsr_q[WAY_W-1:0];

    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(lfsr_q));
endmodule

// File: rtl/freq_track.sv
module freq_track
    import way_victim_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int AGE_PERIOD = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_vld,
    input  way_t acc_way,
    input  logic fill_vld,
    input  way_t fill_way,
    output way_t victim
);
    localparam int                AGE_W   = (AGE_PERIOD > 2) ? $clog2(AGE_PERIOD) : 1;
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [AGE_W-1:0]  AGE_END = AGE_W'(AGE_PERIOD - 1);

    logic [AGE_W-1:0] age_q;
    logic             age_now;
    logic [CNT_W-1:0] cnt_q [NWAYS];

    assign age_now = acc_vld && (age_q == AGE_END);

    always_ff @(posedge clk) begin
        if (rst)          age_q <= '0;
        else if (age_now) age_q <= '0;
        else if (acc_vld) age_q <= age_q + AGE_W'(1);
    end

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        logic             fill_me, hit_me;
        logic [CNT_W-1:0] base;

        assign fill_me = fill_vld && (fill_way == way_t'(g));
        assign hit_me  = acc_vld  && (acc_way  == way_t'(g));

        always_comb begin
            if (fill_me)     base = CNT_W'(1);
            else if (hit_me) base = (cnt_q[g] == CNT_MAX) ? CNT_MAX : cnt_q[g] + CNT_W'(1);
            else             base = cnt_q[g];
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q[g] <= '0;
            else     cnt_q[g] <= age_now ? (base >> 1) : base;
        end

        p_cnt_sat_r7: assert property (@(posedge clk) disable iff (rst)
            (hit_me && !fill_me && !age_now && cnt_q[g] == CNT_MAX) |=> (cnt_q[g] == CNT_MAX));

        p_cnt_halved_r9: assert property (@(posedge clk) disable iff (rst)
            age_now |=> (cnt_q[g] <= (CNT_MAX >> 1)));
    end

    always_comb begin
        victim = '0;
        for (int i = 1; i < NWAYS; i++) begin
            if (cnt_q[i] < cnt_q[victim]) victim = way_t'(i);
        end
    end

    p_min_count_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q[victim] <= cnt_q[0]);
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import way_victim_pkg::*;
#(
    parameter int                CNT_W      = 4,
    parameter int                AGE_PERIOD = 64,
    parameter logic [LFSR_W-1:0] SEED       = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       policy_i,
    input  logic             acc_vld_i,
    input  logic [WAY_W-1:0] acc_way_i,
    input  logic             fill_vld_i,
    input  logic [WAY_W-1:0] fill_way_i,
    input  logic             vic_req_i,
    input  logic [NWAYS-1:0] way_valid_i,
    output logic [WAY_W-1:0] victim_o
);
    repl_pol_e pol;
    way_t      v_tree, v_round, v_rand, v_freq, v_pol, v_inval;
    logic      any_inval;

    assign pol = repl_pol_e'(policy_i);

    tree_plru u_tree (
        .clk(clk), .rst(rst),
        .acc_vld(acc_vld_i), .acc_way(acc_way_i),
        .fill_vld(fill_vld_i), .fill_way(fill_way_i),
        .victim(v_tree)
    );

    round_ptr u_round (
        .clk(clk), .rst(rst),
        .fill_vld(fill_vld_i),
        .victim(v_round)
    );

    lfsr_pick #(.SEED(SEED)) u_rand (
        .clk(clk), .rst(rst),
        .step(vic_req_i),
        .victim(v_rand)
    );

    freq_track #(.CNT_W(CNT_W), .AGE_PERIOD(AGE_PERIOD)) u_freq (
        .clk(clk), .rst(rst),
        .acc_vld(acc_vld_i), .acc_way(acc_way_i),
        .fill_vld(fill_vld_i), .fill_way(fill_way_i),
        .victim(v_freq)
    );

    always_comb begin
        unique case (pol)
            POL_TREE:  v_pol = v_tree;
            POL_ROUND: v_pol = v_round;
            POL_RAND:  v_pol = v_rand;
            default:   v_pol = v_freq;
        endcase
    end

    always_comb begin
        any_inval = 1'b0;
        v_inval   = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (!way_valid_i[i]) begin
                any_inval = 1'b1;
                v_inval   = way_t'(i);
            end
        end
    end

    assign victim_o = any_inval ? v_inval : v_pol;

    p_invalid_first_r2: assert property (@(posedge clk) disable iff (rst)
        (way_valid_i != '1) |-> !way_valid_i[victim_o]);
endmodule

// File: tb/test_way_victim_sel.sv
module test_way_victim_sel;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] policy_i;
    logic       acc_vld_i, fill_vld_i, vic_req_i;
    logic [1:0] acc_way_i, fill_way_i;
    logic [3:0] way_valid_i;
    logic [1:0] victim_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    way_victim_sel #(.AGE_PERIOD(64)) i_way_victim_sel (
        .clk(clk), .rst(rst), .policy_i(policy_i),
        .acc_vld_i(acc_vld_i), .acc_way_i(acc_way_i),
        .fill_vld_i(fill_vld_i), .fill_way_i(fill_way_i),
        .vic_req_i(vic_req_i), .way_valid_i(way_valid_i),
        .victim_o(victim_o)
    );

    task automatic chk(input logic [1:0] exp, input string tag);
        checks++;
        if (victim_o !== exp) begin
            failures++;
            $display("FAIL %s: victim actual=%0d expected=%0d", tag, victim_o, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_vld_i = 0; fill_vld_i = 0; vic_req_i = 0;
        acc_way_i = 0; fill_way_i = 0; way_valid_i = 4'hF;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic hit(input logic [1:0] w, input int n);
        for (int k = 0; k < n; k++) begin
            acc_vld_i = 1'b1; acc_way_i = w;
            @(negedge clk);
            acc_vld_i = 1'b0;
        end
    endtask

    task automatic fill(input logic [1:0] w);
        fill_vld_i = 1'b1; fill_way_i = w;
        @(negedge clk);
        fill_vld_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        policy_i = 2'd0; #1 chk(2'd3, "R1 tree");
        policy_i = 2'd1; #1 chk(2'd0, "R1 round");
        policy_i = 2'd2; #1 chk(2'd1, "R1 random");
        policy_i = 2'd3; #1 chk(2'd0, "R1 freq");
    endtask

    task automatic t_invalid();
        do_reset();
        policy_i = 2'd0;
        way_valid_i = 4'b1010; #1 chk(2'd0, "R2 tree 1010");
        way_valid_i = 4'b1011; #1 chk(2'd2, "R2 tree 1011");
        way_valid_i = 4'b0111; #1 chk(2'd3, "R2 tree 0111");
        policy_i = 2'd3;
        way_valid_i = 4'b1101; #1 chk(2'd1, "R2 freq 1101");
        way_valid_i = 4'hF;
    endtask

    task automatic t_tree();
        do_reset();
        policy_i = 2'd0;
        hit(2'd2, 1); chk(2'd1, "R3 hit way2");
        hit(2'd1, 1); chk(2'd3, "R4 hit way1");
        hit(2'd3, 1); chk(2'd0, "R4 hit way3");
        hit(2'd0, 1); chk(2'd2, "R4 hit way0");
        fill(2'd2);   chk(2'd1, "R3 fill way2");
        // hit and fill together: fill way3 wins -> root 1, hi 1, lo 0 -> way1
        acc_vld_i = 1; acc_way_i = 2'd0; fill_vld_i = 1; fill_way_i = 2'd3;
        @(negedge clk);
        acc_vld_i = 0; fill_vld_i = 0;
        chk(2'd1, "R3 fill priority");
    endtask

    task automatic t_round();
        do_reset();
        policy_i = 2'd1;
        hit(2'd0, 3); chk(2'd0, "R5 hits ignored");
        fill(2'd0);   chk(2'd1, "R5 step 1");
        fill(2'd1);   chk(2'd2, "R5 step 2");
        fill(2'd2);   chk(2'd3, "R5 step 3");
        fill(2'd3);   chk(2'd0, "R5 wrap");
    endtask

    task automatic t_random();
        logic [7:0] m;
        do_reset();
        policy_i = 2'd2;
        m = 8'hA5;
        for (int k = 0; k < 12; k++) begin
            vic_req_i = 1'b1;
            @(negedge clk);
            vic_req_i = 1'b0;
            m = {m[6:0], m[7] ^ m[5] ^ m[4] ^ m[3]};
            chk(m[1:0], "R6 sequence");
        end
        hit(2'd3, 2); chk(m[1:0], "R6 hits do not step");
    endtask

    task automatic t_freq();
        do_reset();
        policy_i = 2'd3;
        fill(2'd1); fill(2'd2); fill(2'd3);
        chk(2'd0, "R7 fills set one");
        hit(2'd0, 17);
        hit(2'd1, 13); hit(2'd2, 13); hit(2'd3, 13);
        chk(2'd1, "R7 saturation at 15");
        hit(2'd1, 1); hit(2'd2, 1); hit(2'd3, 1);
        chk(2'd0, "R8 tie lowest index");
        fill(2'd2);
        chk(2'd2, "R7 fill resets count");
    endtask

    task automatic t_aging();
        do_reset();
        policy_i = 2'd3;
        hit(2'd1, 1);
        hit(2'd0, 62);
        chk(2'd2, "R8 before aging");
        hit(2'd0, 1);   // 64th hit: w0 15->7, w1 1->0
        chk(2'd1, "R9 halved");
        hit(2'd1, 1); hit(2'd2, 1);
        chk(2'd3, "R9 counting resumes");
    endtask

    initial begin
        rst = 1'b1; policy_i = 0;
        acc_vld_i = 0; fill_vld_i = 0; vic_req_i = 0;
        acc_way_i = 0; fill_way_i = 0; way_valid_i = 4'hF;
        t_reset();
        t_invalid();
        t_tree();
        t_round();
        t_random();
        t_freq();
        t_aging();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule